// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small first-in first-out store of instruction bytes ahead of an execution consumer. When the external bus is free and the store has room, it issues a single-byte memory read. The read address is built from a 16-bit code segment and a 16-bit fetch pointer. Returned bytes go into the store in order. The consumer pops them at its own pace, in the same cycles that fetching goes on.

A change of program flow is signalled with a one-cycle flush that carries a new segment and offset. The flush discards every queued byte and restarts fetching at the new target. A read that was already outstanding is allowed to complete, but its byte is thrown away. The block also presents the offset of the next byte the consumer will execute, which is what a call or interrupt would save. This offset is not the next byte to be fetched.

Top module: `prefetch_queue`

## Requirements
- R1: The store holds at most 6 bytes (4 bytes when parameter `NARROW` is 1). When it is full, no read is requested, and with no pops it ends up holding exactly that many bytes.
- R2: `rd_req` is high only in a cycle where `bus_busy` is low, `flush` is low and no earlier read is still waiting for `rd_ack`. A read is outstanding from the clock edge where `rd_req` was high until the edge where `rd_ack` is high, at least one cycle later.
- R3: `rd_addr` equals segment × 16 plus the fetch offset, truncated to 20 bits.
- R4: Each accepted byte advances the fetch offset by one, and the offset wraps from 0xFFFF to 0x0000 within the same segment.
- R5: `q_valid` is high whenever the store is non-empty, and `q_data` shows the oldest byte. A pop with `q_valid` high removes that byte at the clock edge.
- R6: A flush empties the store at its clock edge and loads the new segment and offset, which the next read uses. A pop or an `rd_ack` in the flush cycle is ignored.
- R7: If a read is outstanding when a flush occurs, its byte is dropped when `rd_ack` returns.
- R8: `exec_off` equals the fetch offset minus the number of stored bytes, modulo 65536. It is 0 after reset, equals the flush offset right after a flush, and rises by one on each pop.
- R9: A byte accepted in the same cycle as a pop leaves the occupancy unchanged.
- R10: After reset the store is empty, the segment and offset are 0, and no read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_busy | input | 1 | External bus occupied; blocks new reads |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 20 | Physical byte address of the request |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Returned byte |
| pop | input | 1 | Consumer takes the oldest byte |
| q_valid | output | 1 | Store holds at least one byte |
| q_data | output | 8 | Oldest stored byte |
| flush | input | 1 | Discard store and redirect fetching |
| flush_seg | input | 16 | New code segment |
| flush_off | input | 16 | New fetch offset |
| exec_off | output | 16 | Offset of next byte to execute |

## Verification
A corrupted fetch offset or segment shows up at the first popped byte after the fault: every byte the memory model returns is a function of its address, so a wrong address gives a wrong value. An occupancy count that drifts from the true fill level shows up in the same cycle as a mismatch between `exec_off` and the running count of popped bytes. It also shows up as a wrong number of bytes drained from a full store. A stale byte wrongly kept across a flush appears as the first byte popped at the new target.

// File: rtl/prefetch_queue.sv
`timescale 1ns/1ps
module prefetch_queue #(
  parameter bit NARROW = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_busy,
  output logic        rd_req,
  output logic [19:0] rd_addr,
  input  logic        rd_ack,
  input  logic [7:0]  rd_data,
  input  logic        pop,
  output logic        q_valid,
  output logic [7:0]  q_data,
  input  logic        flush,
  input  logic [15:0] flush_seg,
  input  logic [15:0] flush_off,
  output logic [15:0] exec_off
);
  localparam int DEPTH = NARROW ? 4 : 6;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [15:0]   seg, off;
  logic          pending, stale;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire full = (count == CW'(DEPTH));
  wire push = rd_ack && pending && !stale && !flush;
  wire take = pop && q_valid && !flush;

  assign q_valid  = (count != '0);
  assign q_data   = store[rd_ptr];
  assign rd_req   = !bus_busy && !pending && !full && !flush;
  assign rd_addr  = {seg, 4'h0} + {4'h0, off};
  assign exec_off = off - 16'(count);

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      seg     <= '0;
      off     <= '0;
      pending <= 1'b0;
      stale   <= 1'b0;
    end else if (flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      seg     <= flush_seg;
      off     <= flush_off;
      pending <= pending && !rd_ack;
      stale   <= pending && !rd_ack;
    end else begin
      if (rd_req) pending <= 1'b1;
      else if (rd_ack) begin
        pending <= 1'b0;
        stale   <= 1'b0;
      end
      if (push) begin
        wr_ptr <= bump(wr_ptr);
        off    <= off + 16'd1;
      end
      if (take) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(take);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q_valid && exec_off == $past(flush_off)); // R6
  AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && !take |=> exec_off == $past(exec_off)); // R8
  AST_PAIR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    push && take |=> $stable(count)); // R9
  AST_STALE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    stale && rd_ack && !take && !flush |=> $stable(count)); // R7
endmodule

// File: tb/prefetch_queue_test.sv
`timescale 1ns/1ps
module prefetch_queue_test;
  localparam int DEPTH = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_busy = 1'b1, rd_ack = 1'b0, pop = 1'b0, flush = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic [15:0] flush_seg = '0, flush_off = '0;
  logic rd_req, q_valid;
  logic [19:0] rd_addr;
  logic [7:0] q_data;
  logic [15:0] exec_off;

  int errors = 0, checks = 0, npops = 0, lat = 1;
  bit mem_pend = 1'b0;
  int mem_wait = 0;
  logic [19:0] mem_addr = '0;
  logic [15:0] exp_seg = '0, exp_off = '0;

  always #2 clk = ~clk;

  prefetch_queue uut (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .pop(pop),
    .q_valid(q_valid), .q_data(q_data), .flush(flush),
    .flush_seg(flush_seg), .flush_off(flush_off), .exec_off(exec_off)
  );

  function automatic logic [7:0] fbyte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit do_pop, input bit busy, input bit do_flush,
                      input logic [15:0] fs, input logic [15:0] fo);
    bit pend_before;
    @(negedge clk);
    chk(exec_off == exp_off, "R8", exec_off, exp_off);
    pend_before = mem_pend;
    rd_ack = 1'b0;
    if (mem_pend) begin
      if (mem_wait <= 1) begin
        rd_ack = 1'b1; rd_data = fbyte(mem_addr); mem_pend = 1'b0;
      end else mem_wait--;
    end
    pop = 1'b0;
    if (do_pop && q_valid && !do_flush) begin
      chk(q_data == fbyte(phys(exp_seg, exp_off)), "R5 R3 R4", q_data, fbyte(phys(exp_seg, exp_off)));
      pop = 1'b1; exp_off++; npops++;
    end
    bus_busy = busy; flush = do_flush; flush_seg = fs; flush_off = fo;
    if (do_flush) begin exp_seg = fs; exp_off = fo; end
    #1;
    if (rd_req) begin
      chk(!busy && !pend_before && !do_flush, "R2", {busy, pend_before, do_flush}, 0);
      mem_pend = 1'b1; mem_wait = lat; mem_addr = rd_addr;
    end
  endtask

  task automatic drain_count(input int expect_n, input string req);
    npops = 0;
    repeat (DEPTH + 4) step(1, 1, 0, 0, 0);
    chk(npops == expect_n, req, npops, expect_n);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; bus_busy = 1'b0;
    #1;
    chk(q_valid == 1'b0, "R10", q_valid, 0);
    chk(exec_off == 16'h0, "R10", exec_off, 0);
    chk(rd_addr == 20'h0, "R10", rd_addr, 0);
    chk(rd_req == 1'b1, "R10", rd_req, 1);
    bus_busy = 1'b1;

    for (int l = 1; l <= 3; l++) begin
      lat = l;
      step(0, 1, 1, 16'h1400, 16'h1200);
      repeat (12 * DEPTH) step(0, 0, 0, 0, 0);
      chk(rd_req == 1'b0, "R1", rd_req, 0);
      chk(q_valid == 1'b1, "R1", q_valid, 1);
      drain_count(DEPTH, "R1");
    end

    lat = 1;
    step(0, 1, 1, 16'h2000, 16'h0000);
    repeat (4 * DEPTH) step(0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);   // R9: the refilled byte and this pop land on the same edge
    drain_count(DEPTH - 1, "R9");

    repeat (3 * DEPTH) step(0, 0, 0, 0, 0);
    step(0, 1, 1, 16'h3000, 16'h0040);
    step(0, 1, 0, 0, 0);
    chk(q_valid == 1'b0, "R6", q_valid, 0);
    chk(rd_addr == 20'h30040, "R6 R3", rd_addr, 20'h30040);

    lat = 3;
    step(0, 1, 1, 16'h4000, 16'h0000);
    step(0, 0, 0, 0, 0);
    step(0, 1, 1, 16'h5123, 16'h0777);   // R7: read in flight across this flush
    repeat (8) step(0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);

    lat = 1;
    step(0, 1, 1, 16'hFFFF, 16'hFFFC);   // R3 20-bit wrap and R4 offset wrap
    repeat (40) step(1, 0, 0, 0, 0);
    chk(exp_off[15:8] == 8'h00, "R4", exp_off, 16'h0000);

    for (int l = 1; l <= 3; l++) begin
      lat = l;
      for (int i = 0; i < 3000; i++) begin
        automatic int r = $urandom_range(0, 99);
        step(r < 55, r % 5 == 0, r >= 97, 16'($urandom), 16'($urandom));
      end
    end

    step(0, 1, 1, 16'h0010, 16'hFFF0);
    step(0, 1, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule